// File: doc/BRIEF.md
# Byte-Parallel Configuration Serializer

This block takes a configuration bitstream one byte at a time from a parallel bus and turns it into a serial stream for a chain of downstream devices. All timing comes from an externally supplied configuration clock: there is no handshake, and a new byte is taken on a fixed schedule. The first byte is captured on the first rising edge after reset is released. Every later byte is captured exactly eight rising edges after the one before it. Each capture is confirmed by a one-clock acknowledge pulse, which is mainly useful for test.

Each byte is shifted out most significant bit first. The serial output has an internal latency of one and a half clocks and changes only on the falling clock edge, so the next device in the chain can sample it on the following rising edge. When no data bit is being shifted, the output idles high. The host marks the final byte with a last flag. After that byte, the block counts a fixed flush of ten rising edges plus one per chained device, then raises a sticky done flag.

Top module: `cfg_serializer`

## Requirements
- R1: The byte on `cfg_byte` is captured on the first rising edge at which `rst` is low after a reset.
- R2: After any capture that is not marked last, the next byte is captured on exactly the eighth rising edge after it, with no other capture in between.
- R3: `cfg_ack` is high for the single clock period that follows each capturing rising edge, and it is low at all other times.
- R4: The bits of each captured byte appear on `ser_out` in order from bit 7 down to bit 0, one bit per clock, with no gap between consecutive bytes.
- R5: `ser_out` changes only on falling clock edges. Bit 7 of a byte captured at rising edge k is driven from the falling edge that follows rising edge k+1, and each following bit arrives one clock later.
- R6: Whenever no captured data bit is due, `ser_out` is 1.
- R7: If `cfg_last` is high at a capturing edge k, `flush_done` rises at rising edge k+10+CHAIN_DEVS (CHAIN_DEVS defaults to 2) and not before.
- R8: Once `flush_done` is high, it stays high and no further byte is captured (no `cfg_ack`), until reset.
- R9: Values on `cfg_byte` and `cfg_last` at rising edges that are not capture edges have no effect on `ser_out`, `cfg_ack` or `flush_done`.
- R10: A rising edge with `rst` high clears `cfg_ack` and `flush_done`, and it sets `ser_out` to 1 from the next falling edge. It also restarts the schedule, so the next edge with `rst` low captures the first byte again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock, externally supplied |
| rst | input | 1 | Synchronous active-high reset |
| cfg_byte | input | 8 | Parallel configuration byte |
| cfg_last | input | 1 | Marks the byte at the current capture edge as the final byte |
| cfg_ack | output | 1 | One-clock acknowledge after each byte capture |
| ser_out | output | 1 | Serial stream to the next chained device; updates on falling edges |
| flush_done | output | 1 | Sticky flag: the trailing flush clocks have elapsed |

## Verification
The assertions assume that `rst` is held for at least one full rising edge, and that `cfg_byte` and `cfg_last` are steady across every rising edge. The schedule properties also assume that the byte width is a power of two, so the phase counter wraps by itself. The stimulus changes its inputs one nanosecond after each rising edge and keeps reset asserted for several edges. It also places deliberately random values on the bus and the last flag between capture edges, and after the flush has completed, to show that those values are ignored. One run pulls reset in the middle of a stream, which checks that the schedule restarts cleanly.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;

    // Fixed part of the trailing flush, in rising edges
    localparam int FLUSH_BASE = 10;

    typedef enum logic [1:0] {
        SEQ_WAIT,   // waiting for the first byte after reset
        SEQ_LOAD,   // bytes being accepted on the fixed schedule
        SEQ_FLUSH,  // final byte taken, counting flush edges
        SEQ_DONE    // flush complete
    } seq_state_t;

    typedef struct packed {
        logic capture;  // this rising edge takes a byte
        logic ack;      // registered acknowledge
        logic done;     // flush completed
    } seq_ctl_t;

    function automatic int flush_cycles(input int chain_devs);
        return FLUSH_BASE + chain_devs;
    endfunction

endpackage

// File: rtl/cfgser_sequencer.sv
module cfgser_sequencer
    import cfgser_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int CHAIN_DEVS = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     last_in,
    output seq_ctl_t ctl
);
    localparam int PH_W      = $clog2(BYTE_W);
    localparam int FLUSH_LEN = flush_cycles(CHAIN_DEVS);
    localparam int FL_W      = $clog2(FLUSH_LEN + 1);

    seq_state_t       state;
    logic [PH_W-1:0]  phase;
    logic [FL_W-1:0]  fcnt;
    logic             capture;
    logic             ack_q;

    always_comb begin
        capture = (state == SEQ_WAIT) ||
                  ((state == SEQ_LOAD) && (phase == PH_W'(BYTE_W - 1)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_WAIT;
            phase <= '0;
            fcnt  <= '0;
            ack_q <= 1'b0;
        end else begin
            ack_q <= capture;
            if (capture) begin
                phase <= '0;
                fcnt  <= '0;
                state <= last_in ? SEQ_FLUSH : SEQ_LOAD;
            end else begin
                phase <= phase + 1'b1;
                if (state == SEQ_FLUSH) begin
                    fcnt <= fcnt + 1'b1;
                    if (fcnt == FL_W'(FLUSH_LEN - 1))
                        state <= SEQ_DONE;
                end
            end
        end
    end

    always_comb begin
        ctl.capture = capture;
        ctl.ack     = ack_q;
        ctl.done    = (state == SEQ_DONE);
    end

    // R3: acknowledge never lasts more than one clock
    assert_ack_single_R3: assert property (@(posedge clk) disable iff (rst)
        ack_q |=> !ack_q);

    // R8: done is sticky until reset
    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        ctl.done |=> ctl.done);

    // R8: no acknowledge after done
    assert_no_ack_after_done_R8: assert property (@(posedge clk) disable iff (rst)
        ctl.done |=> !ack_q);

endmodule

// File: rtl/cfgser_shifter.sv
module cfgser_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    output logic              msb_q
);
    logic [BYTE_W-1:0] sr;

    // Shift register: loads on capture, otherwise moves left filling ones
    always_ff @(posedge clk) begin
        if (rst)
            sr <= '1;
        else if (load)
            sr <= din;
        else
            sr <= {sr[BYTE_W-2:0], 1'b1};
    end

    // Second rising-edge stage: one full clock of the 1.5-clock latency
    always_ff @(posedge clk) begin
        if (rst)
            msb_q <= 1'b1;
        else
            msb_q <= sr[BYTE_W-1];
    end

    // R6: idle fill enters at the bottom whenever no byte is loaded
    assert_fill_ones_R6: assert property (@(posedge clk) disable iff (rst)
        !load |=> sr[0]);

endmodule

// File: rtl/cfgser_retime.sv
module cfgser_retime (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic bit_out
);
    // Falling-edge stage: the last half clock of the latency
    always_ff @(negedge clk) begin
        if (rst)
            bit_out <= 1'b1;
        else
            bit_out <= bit_in;
    end

endmodule

// File: rtl/cfg_serializer.sv
module cfg_serializer
    import cfgser_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int CHAIN_DEVS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] cfg_byte,
    input  logic              cfg_last,
    output logic              cfg_ack,
    output logic              ser_out,
    output logic              flush_done
);
    localparam int GAP_MAX = 2 * BYTE_W;
    localparam int GAP_W   = $clog2(GAP_MAX + 1);

    seq_ctl_t ctl;
    logic     pipe_bit;

    cfgser_sequencer #(
        .BYTE_W    (BYTE_W),
        .CHAIN_DEVS(CHAIN_DEVS)
    ) seq_i (
        .clk    (clk),
        .rst    (rst),
        .last_in(cfg_last),
        .ctl    (ctl)
    );

    cfgser_shifter #(
        .BYTE_W(BYTE_W)
    ) shf_i (
        .clk  (clk),
        .rst  (rst),
        .load (ctl.capture),
        .din  (cfg_byte),
        .msb_q(pipe_bit)
    );

    cfgser_retime rt_i (
        .clk    (clk),
        .rst    (rst),
        .bit_in (pipe_bit),
        .bit_out(ser_out)
    );

    assign cfg_ack    = ctl.ack;
    assign flush_done = ctl.done;

    // Checker state: clocks since the previous acknowledge
    logic [GAP_W-1:0] ack_gap;
    logic             ack_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_gap  <= '0;
            ack_seen <= 1'b0;
        end else if (cfg_ack) begin
            ack_gap  <= GAP_W'(1);
            ack_seen <= 1'b1;
        end else if (ack_gap != GAP_W'(GAP_MAX)) begin
            ack_gap  <= ack_gap + 1'b1;
        end
    end

    // R2: consecutive acknowledges are exactly one byte period apart
    assert_byte_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_ack && ack_seen) |-> (ack_gap == GAP_W'(BYTE_W)));

    // R5: the serial output does not move at a rising edge
    assert_out_stable_R5: assert property (@(posedge clk) disable iff (rst)
        ser_out == pipe_bit || $past(rst));

endmodule

// File: tb/cfg_serializer_tb_top.sv
module cfg_serializer_tb_top;
    localparam int BYTE_W     = 8;
    localparam int CHAIN_DEVS = 2;
    localparam int FLUSH_LEN  = 10 + CHAIN_DEVS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] d   = 8'h00;
    logic       l   = 1'b0;
    logic       ack, sdo, done;

    always #2 clk = ~clk;   // 250 MHz

    cfg_serializer #(.BYTE_W(BYTE_W), .CHAIN_DEVS(CHAIN_DEVS)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_byte  (d),
        .cfg_last  (l),
        .cfg_ack   (ack),
        .ser_out   (sdo),
        .flush_done(done)
    );

    int checks   = 0;
    int failures = 0;

    // Reference model state
    int   m_n;
    bit   m_stop, m_done;
    int   m_left;
    bit   q[$];
    bit   prev_msb, prev_data;
    bit   exp_sdo, exp_data, exp_ack, first_cap;
    bit   armed = 0;
    bit   noise = 0;
    logic [7:0] bytes [4];

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge(input bit r, input logic [7:0] dv, input bit lv);
        bit cap, msb, msb_data;
        if (r) begin
            m_n = 0; m_stop = 0; m_done = 0; m_left = 0;
            q.delete();
            prev_msb = 1; prev_data = 0;
            exp_sdo = 1; exp_data = 0; exp_ack = 0; first_cap = 0;
            return;
        end
        cap = !m_stop && (m_n % 8 == 0);
        first_cap = cap && (m_n == 0);
        if (m_stop && !m_done) begin
            m_left--;
            if (m_left == 0) m_done = 1;
        end
        if (cap) begin
            for (int i = 7; i >= 0; i--) q.push_back(dv[i]);
            if (lv) begin m_stop = 1; m_left = FLUSH_LEN; end
        end
        m_n++;
        if (q.size() > 0) begin msb = q.pop_front(); msb_data = 1; end
        else begin msb = 1; msb_data = 0; end
        exp_sdo  = prev_msb;
        exp_data = prev_data;
        prev_msb = msb;
        prev_data = msb_data;
        exp_ack  = cap;
    endtask

    task automatic step(input bit nr, input logic [7:0] nd, input bit nl);
        bit r_edge;
        string ack_tag, sdo_tag;
        @(posedge clk); #1;
        if (armed) chk("R5 hold across rising edge", {7'd0, sdo}, {7'd0, exp_sdo});
        r_edge = rst;
        model_edge(rst, d, l);
        if (r_edge)         ack_tag = "R10 ack";
        else if (first_cap) ack_tag = "R1 ack";
        else if (exp_ack)   ack_tag = "R2 ack";
        else if (m_done)    ack_tag = "R8 ack";
        else                ack_tag = "R3 ack";
        chk(ack_tag, {7'd0, ack}, {7'd0, exp_ack});
        chk(r_edge ? "R10 done" : (m_done ? "R7/R8 done" : "R7 done"),
            {7'd0, done}, {7'd0, m_done});
        rst = nr; d = nd; l = nl;
        @(negedge clk); #1;
        if (r_edge)        sdo_tag = "R10 sdo";
        else if (noise)    sdo_tag = "R9 sdo";
        else if (exp_data) sdo_tag = "R4 sdo";
        else               sdo_tag = "R6 sdo";
        chk(sdo_tag, {7'd0, sdo}, {7'd0, exp_sdo});
        armed = 1;
    endtask

    // Reset, then stream 'count' bytes; stop after max_steps steps
    task automatic run_stream(input int count, input int tail, input int max_steps);
        int total, nxt, idx;
        logic [7:0] nd;
        bit nl;
        step(1, 8'h00, 0);
        step(1, 8'h00, 0);
        step(0, bytes[0], count == 1);
        total = count * 8 + FLUSH_LEN + tail;
        if (max_steps < total) total = max_steps;
        for (int n = 0; n < total; n++) begin
            nxt = n + 1;
            idx = nxt / 8;
            if ((nxt % 8 == 0) && (idx < count)) begin
                nd = bytes[idx];
                nl = (idx == count - 1);
            end else if (noise || idx >= count) begin
                nd = 8'($urandom);
                nl = 1'($urandom);
            end else begin
                nd = d;
                nl = 0;
            end
            step(0, nd, nl);
        end
    endtask

    initial begin
        // Run A: single byte, flush and tail (R1, R4, R6, R7, R8)
        bytes[0] = 8'hA5; bytes[1] = 8'h00; bytes[2] = 8'h00; bytes[3] = 8'h00;
        run_stream(1, 20, 1000);
        // Run B: four bytes with edge patterns (R2, R3, R4)
        bytes[0] = 8'h00; bytes[1] = 8'hFF; bytes[2] = 8'h3C; bytes[3] = 8'h81;
        run_stream(4, 16, 1000);
        // Run C: random bus and last flag between captures (R9)
        noise = 1;
        bytes[0] = 8'h5A; bytes[1] = 8'hC3; bytes[2] = 8'h17; bytes[3] = 8'h00;
        run_stream(3, 16, 1000);
        noise = 0;
        // Run D: reset in mid-stream (R10), then a full run again
        bytes[0] = 8'h96; bytes[1] = 8'h69; bytes[2] = 8'hF0; bytes[3] = 8'h0F;
        run_stream(4, 0, 13);
        run_stream(4, 8, 1000);
        step(0, 8'h00, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule